// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the digital control front end of a voltage-output converter fed over a three-wire serial port. A host frames a transfer by pulling an active-low frame select low, then presents data bits that are captured on each falling edge of the serial clock. A transfer of exactly one data word (16 bits, MSB first) is kept as a staged word. That word reaches the converter register in one of two ways. A falling edge on the active-low load input copies it in. If the load input is held low, the register updates on its own when a complete frame ends.

All serial pins and control inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are detected in the system clock domain. The serial output is open-drain and is modelled as a pull-low enable. In normal operation it presents the MSB of the input shift register, which lets several parts be chained. While the active-low readback input is held low, it instead shifts out the converter register, advancing on rising serial clock edges. A level-sensitive active-low clear forces the output code to zero and leaves every stored register as it is. A power-down input drops the output-valid flag.

The frame state machine has four states. FR_IDLE waits for a frame. FR_SHIFT counts bits. FR_FULL means exactly one word has been received. FR_OVER means the frame is too long. Its transitions are:
- idle-to-shift on a frame start
- shift-to-full on the sixteenth bit
- full-to-over on any further bit
- any state back to idle on frame end, which is a completed transfer only when it leaves FR_FULL

Top module: `sdac_front`

## Requirements
- R1: Bits are shifted MSB first. With the load input held low, a frame of exactly 16 bits sets the output code to the received word after the frame select returns high.
- R2: A frame of fewer or more than 16 bits changes neither the staged word nor the converter register. A later load edge therefore reproduces the last complete word.
- R3: With the load input high, a completed frame leaves the output code unchanged. A falling edge on the load input then copies the staged word into the converter register.
- R4: While the readback input is low, the serial output presents the converter register MSB first. The first bit (bit 15) appears before the first clock pulse, and the output advances one bit on each rising serial clock edge.
- R5: While readback is off, the serial output presents bit 15 of the input shift register before each falling serial clock edge. During a frame, the previously written bits therefore stream out for daisy-chaining.
- R6: The pull-low output is 1 exactly when the serial output bit is 0. After reset it is 1, because the shift register is zero.
- R7: While clear is low, the output code is 0. Clear does not change the converter register, including a load that happens in the same cycle.
- R8: When clear returns high, the output code returns to the current converter register value without any new transfer.
- R9: While power-down is high, the output-valid flag is 0 and the output code keeps its value. The flag returns to 1 when power-down is released.
- R10: During reset the output code is 0 and the valid flag is 0, and both registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock, idles high |
| frame_n_i | input | 1 | Active-low frame select |
| load_n_i | input | 1 | Active-low load of the staged word |
| rdbk_n_i | input | 1 | Active-low readback enable |
| clr_n_i | input | 1 | Active-low level-sensitive output clear |
| pwrdn_i | input | 1 | Power-down request, active high |
| ser_din_i | input | 1 | Serial data input |
| sdo_pull_low_o | output | 1 | Open-drain enable: 1 pulls the serial output low |
| code_o | output | 16 | Output code driven to the converter |
| code_valid_o | output | 1 | Output code valid (0 while powered down) |

## Verification
Two functions can fall in the same system cycle: a load of the converter register and an active clear. The bench provokes this by lowering the clear and load pins at the same instant, so both pass through equal synchronizers and act on one edge. It then checks three things. The code must read 0 while clear holds. A readback taken during the clear must show the newly loaded word. Releasing clear must bring that word to the output.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_FULL,
        FR_OVER
    } fr_state_e;

    localparam int IX_SCLK  = 0;
    localparam int IX_FRAME = 1;
    localparam int IX_LOAD  = 2;
    localparam int IX_RDBK  = 3;
    localparam int IX_CLR   = 4;
    localparam int IX_PD    = 5;
    localparam int IX_SDI   = 6;
    localparam int N_IN     = 7;

    // idle levels: serial clock, frame, load, readback, clear high; pd, sdi low
    localparam logic [N_IN-1:0] IN_IDLE = 7'b0011111;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int               N    = 7,
    parameter logic [N-1:0]     IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= IDLE[g];
                stab_q <= IDLE[g];
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end

        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
    import sdac_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              bit_strobe,
    input  logic              sdi,
    output logic [WORD_W-1:0] shreg_q,
    output logic [WORD_W-1:0] staged_q,
    output logic              frame_ok
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    fr_state_e        state_q;
    fr_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: begin
                if (frame_start) state_d = FR_SHIFT;
            end
            FR_SHIFT: begin
                if (frame_end)                              state_d = FR_IDLE;
                else if (bit_strobe && cnt_q == LAST_BIT)   state_d = FR_FULL;
            end
            FR_FULL: begin
                if (frame_end)       state_d = FR_IDLE;
                else if (bit_strobe) state_d = FR_OVER;
            end
            FR_OVER: begin
                if (frame_end) state_d = FR_IDLE;
            end
            default: state_d = FR_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        frame_ok = (state_q == FR_FULL) && frame_end;
    end

    // bit counter, shift register and staged word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shreg_q  <= '0;
            staged_q <= '0;
        end else begin
            if (frame_start) begin
                cnt_q <= '0;
            end else if (state_q == FR_SHIFT && bit_strobe) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q != FR_IDLE && bit_strobe) begin
                shreg_q <= {shreg_q[WORD_W-2:0], sdi};
            end
            if (frame_ok) begin
                staged_q <= shreg_q;
            end
        end
    end

endmodule

// File: rtl/sdac_out.sv
module sdac_out #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_fall,
    input  logic              load_act,
    input  logic              frame_ok,
    input  logic [WORD_W-1:0] shreg,
    input  logic [WORD_W-1:0] staged,
    input  logic              rb_start,
    input  logic              rb_act,
    input  logic              bit_rise,
    input  logic              clr_act,
    input  logic              pd_act,
    output logic [WORD_W-1:0] dac_q,
    output logic              dac_we,
    output logic [WORD_W-1:0] code_o,
    output logic              valid_o,
    output logic              sdo_bit
);

    logic [WORD_W-1:0] dac_d;
    logic [WORD_W-1:0] rb_q;

    always_comb begin
        dac_we = load_fall || (frame_ok && load_act);
        dac_d  = frame_ok ? shreg : staged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q   <= '0;
            rb_q    <= '0;
            code_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            if (dac_we) begin
                dac_q <= dac_d;
            end
            if (rb_start) begin
                rb_q <= dac_q;
            end else if (rb_act && bit_rise) begin
                rb_q <= {rb_q[WORD_W-2:0], 1'b0};
            end
            code_o  <= clr_act ? '0 : dac_q;
            valid_o <= !pd_act;
        end
    end

    always_comb begin
        sdo_bit = rb_act ? rb_q[WORD_W-1] : shreg[WORD_W-1];
    end

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              frame_n_i,
    input  logic              load_n_i,
    input  logic              rdbk_n_i,
    input  logic              clr_n_i,
    input  logic              pwrdn_i,
    input  logic              ser_din_i,
    output logic              sdo_pull_low_o,
    output logic [WORD_W-1:0] code_o,
    output logic              code_valid_o
);

    logic [N_IN-1:0]   pins;
    logic [N_IN-1:0]   s;
    logic [3:0]        prev_q;
    logic              sclk_fall, sclk_rise;
    logic              frame_start, frame_end;
    logic              load_fall, load_act;
    logic              rb_start, rb_act;
    logic              clr_act, pd_act;
    logic [WORD_W-1:0] shreg, staged, dac_q;
    logic              frame_ok, dac_we, sdo_bit;

    always_comb begin
        pins           = '0;
        pins[IX_SCLK]  = ser_clk_i;
        pins[IX_FRAME] = frame_n_i;
        pins[IX_LOAD]  = load_n_i;
        pins[IX_RDBK]  = rdbk_n_i;
        pins[IX_CLR]   = clr_n_i;
        pins[IX_PD]    = pwrdn_i;
        pins[IX_SDI]   = ser_din_i;
    end

    sdac_sync #(.N(N_IN), .IDLE(IN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins),
        .sync_o  (s)
    );

    // previous synchronized level of the four edge-sensitive pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= IN_IDLE[3:0];
        end else begin
            prev_q <= s[3:0];
        end
    end

    always_comb begin
        sclk_fall   = prev_q[IX_SCLK]  && !s[IX_SCLK];
        sclk_rise   = !prev_q[IX_SCLK] &&  s[IX_SCLK];
        frame_start = prev_q[IX_FRAME] && !s[IX_FRAME];
        frame_end   = !prev_q[IX_FRAME] && s[IX_FRAME];
        load_fall   = prev_q[IX_LOAD]  && !s[IX_LOAD];
        load_act    = !s[IX_LOAD];
        rb_start    = prev_q[IX_RDBK]  && !s[IX_RDBK];
        rb_act      = !s[IX_RDBK];
        clr_act     = !s[IX_CLR];
        pd_act      = s[IX_PD];
    end

    sdac_frame #(.WORD_W(WORD_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .bit_strobe  (sclk_fall),
        .sdi         (s[IX_SDI]),
        .shreg_q     (shreg),
        .staged_q    (staged),
        .frame_ok    (frame_ok)
    );

    sdac_out #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_fall (load_fall),
        .load_act  (load_act),
        .frame_ok  (frame_ok),
        .shreg     (shreg),
        .staged    (staged),
        .rb_start  (rb_start),
        .rb_act    (rb_act),
        .bit_rise  (sclk_rise),
        .clr_act   (clr_act),
        .pd_act    (pd_act),
        .dac_q     (dac_q),
        .dac_we    (dac_we),
        .code_o    (code_o),
        .valid_o   (code_valid_o),
        .sdo_bit   (sdo_bit)
    );

    assign sdo_pull_low_o = !sdo_bit;

endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_act,
    input logic              pd_act,
    input logic              frame_ok,
    input logic              dac_we,
    input logic [WORD_W-1:0] dac_q,
    input logic [WORD_W-1:0] staged,
    input logic [WORD_W-1:0] code_o,
    input logic              code_valid_o
);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (code_o == '0));

    assert_release_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_act |=> (code_o == $past(dac_q)));

    assert_pd_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_act |=> !code_valid_o);

    assert_staged_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(staged));

    assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_we |=> $stable(dac_q));

endmodule

bind sdac_front sdac_front_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_act      (clr_act),
    .pd_act       (pd_act),
    .frame_ok     (frame_ok),
    .dac_we       (dac_we),
    .dac_q        (dac_q),
    .staged       (staged),
    .code_o       (code_o),
    .code_valid_o (code_valid_o)
);

// File: tb/sdac_front_bench.sv
`timescale 1ns/1ps
module sdac_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, frame_n = 1'b1, load_n = 1'b1, rdbk_n = 1'b1;
    logic        clr_n = 1'b1, pd = 1'b0, sdi = 1'b0;
    logic        pull_low;
    logic [15:0] code;
    logic        valid;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [15:0] model_sh = '0;

    always #2.5 clk = ~clk;

    sdac_front u_sdac_front (
        .clk            (clk),
        .rst_n          (rst_n),
        .ser_clk_i      (sclk),
        .frame_n_i      (frame_n),
        .load_n_i       (load_n),
        .rdbk_n_i       (rdbk_n),
        .clr_n_i        (clr_n),
        .pwrdn_i        (pwrdn_wire()),
        .ser_din_i      (sdi),
        .sdo_pull_low_o (pull_low),
        .code_o         (code),
        .code_valid_o   (valid)
    );

    function automatic logic pwrdn_wire();
        return pd;
    endfunction

    // word (32), bit count (8), expected code (16)
    localparam logic [55:0] VECS [6] = '{
        {32'h0000A5C3, 8'd16, 16'hA5C3},
        {32'h00001234, 8'd15, 16'hA5C3},
        {32'h00010F0F, 8'd17, 16'hA5C3},
        {32'h0000FFFF, 8'd16, 16'hFFFF},
        {32'h00000001, 8'd16, 16'h0001},
        {32'h00008000, 8'd16, 16'h8000}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected serial output bits for a framed transfer, and model update
    function automatic logic [31:0] daisy_exp(input logic [31:0] w, input int n);
        logic [31:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            c = {c[30:0], model_sh[15]};
            model_sh = {model_sh[14:0], w[i]};
        end
        return c;
    endfunction

    task automatic xfer(input logic [31:0] w, input int n, input bit framed,
                        output logic [31:0] cap);
        cap = '0;
        if (framed) begin
            frame_n = 1'b0;
            tick(4);
        end
        for (int i = n - 1; i >= 0; i--) begin
            sdi = w[i];
            tick(2);
            cap = {cap[30:0], ~pull_low};
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
            tick(4);
        end
        if (framed) begin
            frame_n = 1'b1;
            tick(4);
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] cap;
        logic [31:0] exp_cap;

        // R10 reset state
        tick(3);
        chk("R10 code in reset", code, 0);
        chk("R10 valid in reset", valid, 0);
        chk("R6 pull-low after reset", pull_low, 1);
        rst_n = 1'b1;
        tick(6);
        chk("R9 valid after reset, pd low", valid, 1);

        // table: load held low, auto update at frame end (R1, R2, R5)
        load_n = 1'b0;
        tick(6);
        for (int v = 0; v < 6; v++) begin
            exp_cap = daisy_exp(VECS[v][55:24], int'(VECS[v][23:16]));
            xfer(VECS[v][55:24], int'(VECS[v][23:16]), 1'b1, cap);
            tick(4);
            chk((VECS[v][23:16] == 8'd16) ? "R1 auto update" : "R2 bad length discarded",
                code, VECS[v][15:0]);
            chk("R5 daisy output stream", cap, exp_cap);
        end

        // R3: load high, frame does not reach output until load edge
        load_n = 1'b1;
        tick(6);
        exp_cap = daisy_exp(32'h3C5A, 16);
        xfer(32'h3C5A, 16, 1'b1, cap);
        tick(4);
        chk("R3 no update with load high", code, 16'h8000);
        load_n = 1'b0;
        tick(6);
        chk("R3 load edge copies staged", code, 16'h3C5A);
        load_n = 1'b1;
        tick(6);

        // R2: short frame does not replace staged word
        exp_cap = daisy_exp(32'h7F, 7);
        xfer(32'h7F, 7, 1'b1, cap);
        load_n = 1'b0;
        tick(6);
        chk("R2 short frame leaves staged", code, 16'h3C5A);
        load_n = 1'b1;
        tick(6);

        // R4 readback
        rdbk_n = 1'b0;
        tick(6);
        xfer(32'h0, 16, 1'b0, cap);
        chk("R4 readback stream", cap, 32'h3C5A);
        rdbk_n = 1'b1;
        tick(6);
        chk("R5 R6 pull-low follows shift MSB", pull_low, {31'b0, ~model_sh[15]});

        // R7 R8: clear and load in the same cycle
        exp_cap = daisy_exp(32'h0FF0, 16);
        xfer(32'h0FF0, 16, 1'b1, cap);
        clr_n  = 1'b0;
        load_n = 1'b0;
        tick(6);
        chk("R7 code zero during clear", code, 0);
        load_n = 1'b1;
        rdbk_n = 1'b0;
        tick(6);
        xfer(32'h0, 16, 1'b0, cap);
        chk("R7 register loaded under clear", cap, 32'h0FF0);
        rdbk_n = 1'b1;
        tick(6);
        chk("R7 still zero", code, 0);
        clr_n = 1'b1;
        tick(6);
        chk("R8 release restores code", code, 16'h0FF0);

        // R9 power-down
        pd = 1'b1;
        tick(6);
        chk("R9 valid low in power-down", valid, 0);
        chk("R9 code kept in power-down", code, 16'h0FF0);
        pd = 1'b0;
        tick(6);
        chk("R9 valid restored", valid, 1);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule